// File: doc/BRIEF.md
# Convert-Start SAR Converter Host Sequencer

This block drives an external 16-bit successive-approximation converter that has a convert-start line and a three-wire serial port. When a start is requested it raises the convert line, keeps it high for a programmed pulse time and then for the programmed conversion time, and lowers it while the serial clock is parked high. Lowering the line in that state selects the converter's serial port. The block then runs the serial clock at a programmed half-period. It samples the returned data most significant bit first and shifts a configuration word out on the data-input line.

All timing is counted in system-clock cycles from configuration inputs, so one netlist can serve different clock and I/O voltage conditions. The parameter `N_DEV` sets how many converters are read in a chain. One frame then carries 16×N bits, and the block hands out N results in turn on a valid/ready port, the converter nearest the host first. A free-running spacing timer sets a floor on the time between conversion starts, which caps the sample rate. A new conversion waits until the results of the previous frame have all been accepted.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is asserted, the convert line is low, the serial clock is high, the data-input line is low and no result is valid.
- R2: After a start is accepted, the convert line stays high for exactly `cfg_pulse_cyc + cfg_conv_cyc` clock cycles.
- R3: The serial clock is high for the whole time the convert line is high. The convert line falls only while the serial clock is high, and the serial clock then stays high for `cfg_half_cyc` cycles before its first falling edge.
- R4: During a read, every low phase and every high phase of the serial clock lasts `cfg_half_cyc` cycles. A frame has exactly 16×N_DEV falling edges, and the serial clock ends the frame high.
- R5: The data line is sampled in the last cycle of each high phase, just before the falling edge. The first bit is the one present right after selection, and bits arrive most significant first. Word k of a frame (k = 0 for the nearest converter) is made of bits 16k to 16k+15 in arrival order.
- R6: The data-input line carries `cfg_word` bit 15 first. It changes only on falling serial-clock edges, with the first bit present from the first falling edge. It is driven low for every bit after the sixteenth.
- R7: A result stays valid with unchanged data until `res_ready` is high at a clock edge. Each valid-and-ready edge consumes exactly one word.
- R8: A start request has no effect while a conversion, a read or a result hand-off is in progress. No conversion begins while any result of the previous frame is still pending.
- R9: Two successive rising edges of the convert line are at least `cfg_rate_cyc` clock cycles apart.
- R10: A programmed count of zero behaves as a count of one.
- R11: With `OFFSET_BIN` = 1 the most significant bit of each result is inverted, which turns an offset-binary code into two's complement. With `OFFSET_BIN` = 0 the word is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, level sensitive |
| cfg_pulse_cyc | input | CNT_W | Cycles of the convert pulse |
| cfg_conv_cyc | input | CNT_W | Cycles waited for the conversion to finish |
| cfg_half_cyc | input | CNT_W | Serial-clock half-period in cycles |
| cfg_rate_cyc | input | CNT_W | Minimum cycles between conversion starts |
| cfg_word | input | DATA_W | Word shifted out on the data-input line |
| adc_cnv | output | 1 | Convert-start line |
| adc_sclk | output | 1 | Serial clock |
| adc_din | output | 1 | Data line towards the converter |
| adc_sdo | input | 1 | Data line from the converter |
| res_valid | output | 1 | Result available |
| res_data | output | DATA_W | Result word |
| res_ready | input | 1 | Consumer accepts the result |

## Verification
The bench goes after the instant of selection. A design that let the convert line fall with the serial clock low, or that clocked too early after the fall, would lose or shift the first bit, and every word would come back off by one position. It also checks the edge on which bits are sampled and which way the data-input line is aligned: sampling after the falling edge or shifting the word one edge early gives codes and configuration bits moved by one place. Chained reads with several consumer stall patterns expose a wrong word order and data that changes while stalled. Zero-valued counts, start requests raised in the middle of a frame and a spacing limit longer than the frame catch designs that wrap a counter to its maximum, restart on a stray request, or start conversions too close together.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CONV_PULSE,
      ST_CONV_WAIT,
      ST_SELECT,
      ST_SHIFT,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/sar_host_phase_timer.sv
// Down-counter that times one sequencer phase; a zero load acts as one.
module sar_host_phase_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] eff_val;

   always_comb eff_val = (load_val == '0) ? ONE : load_val;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= eff_val;
      else if (cnt != '0)  cnt <= cnt - ONE;
   end

   assign last = (cnt == ONE);
endmodule

// File: rtl/sar_host_rate_timer.sv
// Free-running spacing counter: restarts at each accepted conversion.
module sar_host_rate_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] period,
   output logic             expired
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] period_eff;

   always_comb period_eff = (period == '0) ? ONE : period;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '1;
      else if (restart)    cnt <= ONE;
      else if (cnt != '1)  cnt <= cnt + ONE;
   end

   assign expired = (cnt >= period_eff);
endmodule

// File: rtl/sar_host_rx_bank.sv
// Capture shift register for one frame and the word presented to the consumer.
module sar_host_rx_bank #(
   parameter int DATA_W     = 16,
   parameter int N_DEV      = 1,
   parameter bit OFFSET_BIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              bit_in,
   input  logic              pop,
   output logic [DATA_W-1:0] word
);
   localparam int TOT = DATA_W * N_DEV;

   logic [TOT-1:0]    sreg;
   logic [DATA_W-1:0] raw;

   generate
      if (N_DEV == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)        sreg <= '0;
            else if (capture)  sreg <= {sreg[TOT-2:0], bit_in};
            else if (pop)      sreg <= '0;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n)        sreg <= '0;
            else if (capture)  sreg <= {sreg[TOT-2:0], bit_in};
            else if (pop)      sreg <= {sreg[TOT-DATA_W-1:0], {DATA_W{1'b0}}};
         end
      end
   endgenerate

   assign raw = sreg[TOT-1 -: DATA_W];

   generate
      if (OFFSET_BIN) begin : g_flip
         assign word = {~raw[DATA_W-1], raw[DATA_W-2:0]};
      end else begin : g_pass
         assign word = raw;
      end
   endgenerate
endmodule

// File: rtl/sar_host_tx_shift.sv
// Configuration word shifter, MSB first, zero-filled behind.
module sar_host_tx_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   input  logic              shift,
   output logic              bit_out
);
   logic [DATA_W-1:0] sreg;

   always_ff @(posedge clk) begin
      if (!rst_n)      sreg <= '0;
      else if (load)   sreg <= word;
      else if (shift)  sreg <= {sreg[DATA_W-2:0], 1'b0};
   end

   assign bit_out = sreg[DATA_W-1];
endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
   import sar_host_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int N_DEV      = 1,
   parameter int CNT_W      = 16,
   parameter bit OFFSET_BIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  cfg_pulse_cyc,
   input  logic [CNT_W-1:0]  cfg_conv_cyc,
   input  logic [CNT_W-1:0]  cfg_half_cyc,
   input  logic [CNT_W-1:0]  cfg_rate_cyc,
   input  logic [DATA_W-1:0] cfg_word,
   output logic              adc_cnv,
   output logic              adc_sclk,
   output logic              adc_din,
   input  logic              adc_sdo,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   input  logic              res_ready
);
   localparam int TOT   = DATA_W * N_DEV;
   localparam int BIT_W = $clog2(TOT + 1);
   localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TOT);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_DEV - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sar_adc_host: DATA_W must be at least 2");
      end
      if (N_DEV < 1) begin : g_bad_chain
         $error("sar_adc_host: N_DEV must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("sar_adc_host: CNT_W must be at least 2");
      end
   endgenerate

   seq_state_e       state, state_d;
   logic             cnv_q, cnv_d;
   logic             sclk_q, sclk_d;
   logic [BIT_W-1:0] bit_cnt, bit_d;
   logic [IDX_W-1:0] idx, idx_d;

   logic             tmr_load, tmr_last;
   logic [CNT_W-1:0] tmr_val;
   logic             rate_restart, rate_ok;
   logic             rx_cap, rx_pop;
   logic             tx_load, tx_shift;

   always_comb begin
      state_d      = state;
      cnv_d        = cnv_q;
      sclk_d       = sclk_q;
      bit_d        = bit_cnt;
      idx_d        = idx;
      tmr_load     = 1'b0;
      tmr_val      = cfg_half_cyc;
      rate_restart = 1'b0;
      rx_cap       = 1'b0;
      rx_pop       = 1'b0;
      tx_load      = 1'b0;
      tx_shift     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            sclk_d = 1'b1;
            if (start && rate_ok) begin
               state_d      = ST_CONV_PULSE;
               cnv_d        = 1'b1;
               tmr_load     = 1'b1;
               tmr_val      = cfg_pulse_cyc;
               rate_restart = 1'b1;
            end
         end
         ST_CONV_PULSE: begin
            if (tmr_last) begin
               state_d  = ST_CONV_WAIT;
               tmr_load = 1'b1;
               tmr_val  = cfg_conv_cyc;
            end
         end
         ST_CONV_WAIT: begin
            if (tmr_last) begin
               state_d  = ST_SELECT;
               cnv_d    = 1'b0;
               tmr_load = 1'b1;
               bit_d    = '0;
            end
         end
         ST_SELECT: begin
            if (tmr_last) begin
               state_d  = ST_SHIFT;
               sclk_d   = 1'b0;
               rx_cap   = 1'b1;
               tx_load  = 1'b1;
               tmr_load = 1'b1;
               bit_d    = bit_cnt + 1'b1;
            end
         end
         ST_SHIFT: begin
            if (tmr_last) begin
               tmr_load = 1'b1;
               if (!sclk_q) begin
                  sclk_d = 1'b1;
                  if (bit_cnt == BIT_LAST) state_d = ST_DONE;
               end else begin
                  sclk_d   = 1'b0;
                  rx_cap   = 1'b1;
                  tx_shift = 1'b1;
                  bit_d    = bit_cnt + 1'b1;
               end
            end
         end
         ST_DONE: begin
            if (res_ready) begin
               rx_pop = 1'b1;
               if (idx == IDX_LAST) begin
                  idx_d   = '0;
                  state_d = ST_IDLE;
               end else begin
                  idx_d = idx + 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnv_q   <= 1'b0;
         sclk_q  <= 1'b1;
         bit_cnt <= '0;
         idx     <= '0;
      end else begin
         state   <= state_d;
         cnv_q   <= cnv_d;
         sclk_q  <= sclk_d;
         bit_cnt <= bit_d;
         idx     <= idx_d;
      end
   end

   sar_host_phase_timer #(.CNT_W(CNT_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   sar_host_rate_timer #(.CNT_W(CNT_W)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rate_restart),
      .period  (cfg_rate_cyc),
      .expired (rate_ok)
   );

   sar_host_rx_bank #(
      .DATA_W     (DATA_W),
      .N_DEV      (N_DEV),
      .OFFSET_BIN (OFFSET_BIN)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rx_cap),
      .bit_in  (adc_sdo),
      .pop     (rx_pop),
      .word    (res_data)
   );

   sar_host_tx_shift #(.DATA_W(DATA_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tx_load),
      .word    (cfg_word),
      .shift   (tx_shift),
      .bit_out (adc_din)
   );

   assign adc_cnv   = cnv_q;
   assign adc_sclk  = sclk_q;
   assign res_valid = (state == ST_DONE);
endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_cnv,
   input logic              adc_sclk,
   input logic              res_valid,
   input logic              res_ready,
   input logic [DATA_W-1:0] res_data,
   input logic [CNT_W-1:0]  cfg_rate_cyc
);
   logic             cnv_seen;
   logic [CNT_W-1:0] gap;
   logic [CNT_W-1:0] rate_eff;

   always_comb rate_eff = (cfg_rate_cyc == '0) ? CNT_W'(1) : cfg_rate_cyc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnv_seen <= 1'b0;
         gap      <= '1;
      end else begin
         cnv_seen <= adc_cnv;
         if (adc_cnv && !cnv_seen) gap <= CNT_W'(1);
         else if (gap != '1)       gap <= gap + CNT_W'(1);
      end
   end

   AST_SELECT_WITH_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cnv) |-> adc_sclk);  // R3
   AST_SCLK_PARKED_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cnv |-> adc_sclk);  // R3
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));  // R7
   AST_NO_CNV_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !adc_cnv);  // R8
   AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_cnv && !cnv_seen) |-> (gap >= rate_eff));  // R9
endmodule

bind sar_adc_host sar_adc_host_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .adc_cnv      (adc_cnv),
   .adc_sclk     (adc_sclk),
   .res_valid    (res_valid),
   .res_ready    (res_ready),
   .res_data     (res_data),
   .cfg_rate_cyc (cfg_rate_cyc)
);

// File: tb/sar_adc_host_test.sv
module sar_adc_host_test;
   localparam int DW = 16;
   localparam int ND = 2;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] cfg_pulse_cyc = 16'd2;
   logic [CW-1:0] cfg_conv_cyc = 16'd5;
   logic [CW-1:0] cfg_half_cyc = 16'd2;
   logic [CW-1:0] cfg_rate_cyc = 16'd40;
   logic [DW-1:0] cfg_word = 16'hC3A5;
   logic          adc_cnv, adc_sclk, adc_din;
   logic          adc_sdo = 1'b1;
   logic          res_valid;
   logic [DW-1:0] res_data;
   logic          res_ready = 1'b0;

   always #4 clk = ~clk;

   sar_adc_host #(.DATA_W(DW), .N_DEV(ND), .CNT_W(CW), .OFFSET_BIN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_pulse_cyc(cfg_pulse_cyc), .cfg_conv_cyc(cfg_conv_cyc),
      .cfg_half_cyc(cfg_half_cyc), .cfg_rate_cyc(cfg_rate_cyc), .cfg_word(cfg_word),
      .adc_cnv(adc_cnv), .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_sdo(adc_sdo),
      .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   function automatic int eff(input logic [CW-1:0] v);
      return (v == '0) ? 1 : int'(v);
   endfunction

   function automatic logic [DW-1:0] code_a(input int k);
      return 16'h8000 + DW'(k * 32'h2F1B);
   endfunction

   function automatic logic [DW-1:0] code_b(input int k);
      return 16'h7FFF - DW'(k * 32'h0D31);
   endfunction

   // behavioural model of the chained converters (offset-binary codes)
   logic [DW-1:0] exp_q[$];
   logic [ND*DW-1:0] chain = '0;
   logic [ND*DW-1:0] rxcfg = '0;
   bit sel = 1'b0;
   bit m_cnv = 1'b0;
   bit m_sclk = 1'b1;
   int conv_k = 0;

   always @(adc_cnv or adc_sclk) begin
      if (adc_cnv && !m_cnv) begin
         sel = 1'b0;
         adc_sdo = 1'b1;
         chain = {code_a(conv_k), code_b(conv_k)};
         exp_q.push_back(code_a(conv_k) ^ 16'h8000);
         exp_q.push_back(code_b(conv_k) ^ 16'h8000);
         conv_k++;
      end else if (!adc_cnv && m_cnv) begin
         sel = adc_sclk;
         rxcfg = '0;
         if (sel) adc_sdo = chain[ND*DW-1];
      end
      if (sel && !adc_sclk && m_sclk) begin
         chain = chain << 1;
         adc_sdo = chain[ND*DW-1];
      end
      if (sel && adc_sclk && !m_sclk) rxcfg = {rxcfg[ND*DW-2:0], adc_din};
      m_cnv = adc_cnv;
      m_sclk = adc_sclk;
   end

   // monitor, sampled away from the active edge
   bit p_cnv = 1'b0, p_sclk = 1'b1, p_valid = 1'b0, p_ready = 1'b0;
   logic [DW-1:0] p_data = '0;
   int hi_cnt = 0, gap = 0, phase = 0, falls = 0, last_hi = 0;
   bit seen_rise = 1'b0, in_frame = 1'b0;
   int results_got = 0;
   bit ready_mode = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         res_ready = ready_mode ? ((cyc % 3) != 0) : 1'b1;
         gap++;
         if (adc_cnv && !p_cnv) begin
            if (seen_rise) chk(gap >= eff(cfg_rate_cyc), "R9", "start spacing",
                               gap, eff(cfg_rate_cyc));
            chk(results_got == (conv_k - 1) * ND, "R8", "results drained before start",
                results_got, (conv_k - 1) * ND);
            seen_rise = 1'b1;
            gap = 0;
         end
         if (adc_cnv) hi_cnt++;
         if (!adc_cnv && p_cnv) begin
            chk(hi_cnt == eff(cfg_pulse_cyc) + eff(cfg_conv_cyc), "R2", "convert high cycles",
                hi_cnt, eff(cfg_pulse_cyc) + eff(cfg_conv_cyc));
            chk(adc_sclk == 1'b1, "R3", "sclk at select", adc_sclk, 1);
            last_hi = hi_cnt;
            hi_cnt = 0;
            in_frame = 1'b1;
            phase = 0;
            falls = 0;
         end else if (in_frame) begin
            phase++;
            if (adc_sclk != p_sclk) begin
               if (falls == 0) chk(phase == eff(cfg_half_cyc), "R3", "hold after select",
                                   phase, eff(cfg_half_cyc));
               else chk(phase == eff(cfg_half_cyc), "R4", "sclk phase length",
                        phase, eff(cfg_half_cyc));
               phase = 0;
               if (!adc_sclk) falls++;
               else if (falls == ND * DW) in_frame = 1'b0;
            end
         end
         if (res_valid && !p_valid) begin
            chk(falls == ND * DW, "R4", "falls per frame", falls, ND * DW);
            chk(adc_sclk == 1'b1, "R4", "sclk ends high", adc_sclk, 1);
            chk(rxcfg == {cfg_word, 16'h0000}, "R6", "config bits seen", rxcfg,
                {cfg_word, 16'h0000});
         end
         if (p_valid && !p_ready)
            chk(res_valid && res_data == p_data, "R7", "held while stalled",
                {res_valid, res_data}, {1'b1, p_data});
         if (res_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected result", res_data, 0);
            else begin
               chk(res_data == exp_q[0], "R5 R11", "result word", res_data, exp_q[0]);
               if (res_ready) begin
                  void'(exp_q.pop_front());
                  results_got++;
               end
            end
         end
         p_valid = res_valid;
         p_ready = res_ready;
         p_data = res_data;
         p_cnv = adc_cnv;
         p_sclk = adc_sclk;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         chk(1'b0, "watchdog", "run did not finish", cyc, 150000);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(adc_cnv == 1'b0, "R1", "convert in reset", adc_cnv, 0);
      chk(adc_sclk == 1'b1, "R1", "sclk in reset", adc_sclk, 1);
      chk(adc_din == 1'b0, "R1", "din in reset", adc_din, 0);
      chk(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // chained reads, stalled consumer, spacing shorter than frame
      start = 1'b1;
      wait (results_got >= 6);
      start = 1'b0;
      repeat (300) @(negedge clk);

      // fast clock, spacing longer than the frame
      cfg_pulse_cyc = 16'd1; cfg_conv_cyc = 16'd3; cfg_half_cyc = 16'd1;
      cfg_rate_cyc = 16'd200; cfg_word = 16'h5A0F; ready_mode = 1'b0;
      start = 1'b1;
      wait (results_got >= 12);
      start = 1'b0;
      repeat (300) @(negedge clk);

      // zero counts behave as one
      cfg_pulse_cyc = '0; cfg_conv_cyc = '0; cfg_half_cyc = '0;
      cfg_rate_cyc = '0; cfg_word = 16'hFFFF; ready_mode = 1'b1;
      start = 1'b1;
      wait (results_got >= 16);
      start = 1'b0;
      repeat (300) @(negedge clk);
      chk(last_hi == 2, "R10", "zero counts convert width", last_hi, 2);

      // start requests during a frame are ignored
      cfg_pulse_cyc = 16'd2; cfg_conv_cyc = 16'd5; cfg_half_cyc = 16'd2;
      begin
         int k0;
         k0 = conv_k;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (30) @(negedge clk);
         start = 1'b1;
         repeat (3) @(negedge clk);
         start = 1'b0;
         repeat (400) @(negedge clk);
         chk(conv_k == k0 + 1, "R8", "conversions after busy request", conv_k, k0 + 1);
      end
      chk(exp_q.size() == 0, "R7", "words left unconsumed", exp_q.size(), 0);
      report();
   end
endmodule